// File: doc/BRIEF.md
# Single-Assignment Store with Parked Readers

The block is a small word-addressed store in which every slot carries a presence tag alongside its data word. The tag says whether the slot has been filled since it was last allocated. A writer fills a slot exactly once. A reader that arrives before the value exists is not stalled and is not sent an error. Its identity is parked inside the store, and the later write answers it automatically. This lets producers and consumers of a value proceed in any order while the result stays determinate.

Requests arrive on two channels that share one ready signal. The write channel carries an address and a data word. The command channel carries either a read, with a requester tag, or an allocate, with a base address and a slot count. Parked readers live in a shared pool that is threaded into one list per slot. When a slot with parked readers is filled, the store releases them through a single response port, one per cycle, and holds ready low until the list is empty. A second write to a filled slot raises an error pulse and is otherwise dropped.

Top module: `istr_mem`

## Requirements
- R1: After reset every slot is empty, no reader is parked, `req_ready` is 1, and `rsp_valid` and `err_dup` are 0.
- R2: An accepted write to an empty slot stores `wr_data` and marks the slot full, so a later read of that slot returns the written word.
- R3: An accepted read (`cmd_alloc`=0) of a full slot gives, in the cycle after acceptance, `rsp_valid`=1, `rsp_busy`=0, `rsp_tag` equal to `cmd_tag`, and `rsp_data` equal to the stored word.
- R4: An accepted read of an empty slot produces no response at that time. Once the slot is written, every reader parked on it receives the written word, one response per cycle, in the order the reads were accepted, starting two cycles after the write is accepted. Readers parked on other slots are not answered.
- R5: From the cycle after a write that releases parked readers until the last of them has been answered, `req_ready` is 0, and write and command requests presented in those cycles have no effect.
- R6: The parked-reader pool holds 16 entries shared by all slots. A read of an empty slot that arrives while all 16 are in use is not recorded; it is answered in the next cycle with `rsp_valid`=1, `rsp_busy`=1 and its own tag.
- R7: A write to a slot that is already full sets `err_dup` to 1 for exactly the next cycle and leaves the stored word unchanged. A write to an empty slot leaves `err_dup` at 0.
- R8: An accepted allocate (`cmd_alloc`=1) marks as empty every slot whose address lies in [`cmd_addr`, `cmd_addr`+`cmd_count`), clipped at the last slot. Readers parked on those slots are discarded without a response, and slots outside the range keep their state.
- R9: When a write and a read to the same empty slot are accepted in the same cycle, the write takes effect first. The read is answered in the next cycle with the written word, ahead of any readers parked earlier on that slot.
- R10: When an allocate and a write are accepted in the same cycle, the allocate takes effect first. A written slot inside the range ends full with the new word, and `err_dup` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ready | output | 1 | Both request channels are accepted in this cycle |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | 4 | Slot address to write |
| wr_data | input | 16 | Word to store |
| cmd_valid | input | 1 | Command request present |
| cmd_alloc | input | 1 | 1: allocate a range, 0: read one slot |
| cmd_addr | input | 4 | Read address, or base address of the allocated range |
| cmd_count | input | 5 | Number of slots to allocate (ignored for reads) |
| cmd_tag | input | 4 | Requester tag returned with the answer to a read |
| rsp_valid | output | 1 | A response is present |
| rsp_busy | output | 1 | The read was refused because the pool was full |
| rsp_tag | output | 4 | Tag of the answered requester |
| rsp_data | output | 16 | Word delivered to the requester |
| err_dup | output | 1 | One-cycle pulse after a write to a full slot |

## Verification
The assertions take for granted that requests are counted only when `req_ready` is high. They also assume that only one command, either a read or an allocate, arrives per cycle, since the two share one channel. The response-port checks further assume the requester consumes every response in the cycle it appears, because the port has no back-pressure. The stimulus issues each request through a task that waits for `req_ready` before presenting it. The only exception is one deliberate case that drives both channels while ready is low, to show that such requests are ignored.

// File: rtl/istr_pkg.sv
package istr_pkg;

    // Controller phase: accepting requests, or releasing a slot's parked readers
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

endpackage

// File: rtl/istr_range_mask.sv
// Decodes an allocate range [base, base+count) into a per-slot hit vector.
module istr_range_mask #(
    parameter int ADDR_W = 4,
    parameter int NSLOT  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W:0]   count,
    output logic [NSLOT-1:0]  hit
);
    localparam int EW = ADDR_W + 2;

    logic [EW-1:0] lo;
    logic [EW-1:0] hi;

    assign lo = EW'(base);
    assign hi = lo + EW'(count);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign hit[g] = (EW'(g) >= lo) && (EW'(g) < hi);
    end
endmodule

// File: rtl/istr_free_pick.sv
// Lowest-index free entry of the parked-reader pool.
module istr_free_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  used,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/istr_mem.sv
module istr_mem
    import istr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int POOL   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_ready,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_valid,
    input  logic              cmd_alloc,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W:0]   cmd_count,
    input  logic [TAG_W-1:0]  cmd_tag,
    output logic              rsp_valid,
    output logic              rsp_busy,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err_dup
);
    localparam int NSLOT  = 1 << ADDR_W;
    localparam int PIDX_W = (POOL > 1) ? $clog2(POOL) : 1;

    typedef struct packed {
        phase_e                          phase;
        logic [NSLOT-1:0]                full;
        logic [NSLOT-1:0][DATA_W-1:0]    data;
        logic [NSLOT-1:0]                has_wait;
        logic [NSLOT-1:0][PIDX_W-1:0]    head;
        logic [NSLOT-1:0][PIDX_W-1:0]    tail;
        logic [POOL-1:0]                 pv;
        logic [POOL-1:0][TAG_W-1:0]      ptag;
        logic [POOL-1:0][PIDX_W-1:0]     pnext;
        logic [POOL-1:0][ADDR_W-1:0]     pslot;
        logic [PIDX_W-1:0]               cur;
        logic [ADDR_W-1:0]               dslot;
        logic                            rsp_v;
        logic                            rsp_b;
        logic [TAG_W-1:0]                rsp_t;
        logic [DATA_W-1:0]               rsp_d;
        logic                            err;
    } state_t;

    state_t state_d, state_q;

    logic [NSLOT-1:0]  alloc_hit;
    logic [PIDX_W-1:0] free_idx;
    logic              free_any;
    logic              wr_go, cmd_go, rd_go, al_go;

    istr_range_mask #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_range (
        .base  (cmd_addr),
        .count (cmd_count),
        .hit   (alloc_hit)
    );

    istr_free_pick #(.N(POOL), .IW(PIDX_W)) u_free (
        .used (state_q.pv),
        .idx  (free_idx),
        .any  (free_any)
    );

    assign req_ready = (state_q.phase == PH_IDLE);
    assign wr_go     = wr_valid  && req_ready;
    assign cmd_go    = cmd_valid && req_ready;
    assign rd_go     = cmd_go && !cmd_alloc;
    assign al_go     = cmd_go &&  cmd_alloc;

    always_comb begin
        state_d       = state_q;
        state_d.rsp_v = 1'b0;
        state_d.rsp_b = 1'b0;
        state_d.rsp_t = '0;
        state_d.rsp_d = '0;
        state_d.err   = 1'b0;

        // Release one parked reader per cycle, oldest first
        if (state_q.phase == PH_DRAIN) begin
            state_d.rsp_v = 1'b1;
            state_d.rsp_t = state_q.ptag[state_q.cur];
            state_d.rsp_d = state_q.data[state_q.dslot];
            state_d.pv[state_q.cur] = 1'b0;
            if (state_q.cur == state_q.tail[state_q.dslot]) begin
                state_d.has_wait[state_q.dslot] = 1'b0;
                state_d.phase = PH_IDLE;
            end else begin
                state_d.cur = state_q.pnext[state_q.cur];
            end
        end

        // Allocate first: empty the range and drop its parked readers
        if (al_go) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (alloc_hit[i]) begin
                    state_d.full[i]     = 1'b0;
                    state_d.has_wait[i] = 1'b0;
                end
            end
            for (int p = 0; p < POOL; p++) begin
                if (state_q.pv[p] && alloc_hit[state_q.pslot[p]]) begin
                    state_d.pv[p] = 1'b0;
                end
            end
        end

        // Then the write
        if (wr_go) begin
            if (state_d.full[wr_addr]) begin
                state_d.err = 1'b1;
            end else begin
                state_d.full[wr_addr] = 1'b1;
                state_d.data[wr_addr] = wr_data;
                if (state_d.has_wait[wr_addr]) begin
                    state_d.phase = PH_DRAIN;
                    state_d.cur   = state_q.head[wr_addr];
                    state_d.dslot = wr_addr;
                end
            end
        end

        // Then the read, which sees the write of the same cycle
        if (rd_go) begin
            if (state_d.full[cmd_addr]) begin
                state_d.rsp_v = 1'b1;
                state_d.rsp_t = cmd_tag;
                state_d.rsp_d = state_d.data[cmd_addr];
            end else if (!free_any) begin
                state_d.rsp_v = 1'b1;
                state_d.rsp_b = 1'b1;
                state_d.rsp_t = cmd_tag;
            end else begin
                state_d.pv[free_idx]    = 1'b1;
                state_d.ptag[free_idx]  = cmd_tag;
                state_d.pslot[free_idx] = cmd_addr;
                if (state_q.has_wait[cmd_addr]) begin
                    state_d.pnext[state_q.tail[cmd_addr]] = free_idx;
                end else begin
                    state_d.has_wait[cmd_addr] = 1'b1;
                    state_d.head[cmd_addr]     = free_idx;
                end
                state_d.tail[cmd_addr] = free_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.phase <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_v;
    assign rsp_busy  = state_q.rsp_b;
    assign rsp_tag   = state_q.rsp_t;
    assign rsp_data  = state_q.rsp_d;
    assign err_dup   = state_q.err;

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !state_q.full[wr_addr])
        |=> (state_q.full[$past(wr_addr)] && state_q.data[$past(wr_addr)] == $past(wr_data))); // R2

    AST_FULL_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && state_q.full[cmd_addr])
        |=> (rsp_valid && !rsp_busy && rsp_tag == $past(cmd_tag)
             && rsp_data == $past(state_q.data[cmd_addr]))); // R3

    AST_DRAIN_FROM_LIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.phase == PH_DRAIN)
        |-> (state_q.pv[state_q.cur] && state_q.full[state_q.dslot])); // R4

    AST_POOL_FULL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !state_q.full[cmd_addr] && !(wr_go && wr_addr == cmd_addr) && (&state_q.pv))
        |=> (rsp_valid && rsp_busy && rsp_tag == $past(cmd_tag))); // R6

    AST_DUP_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !al_go && state_q.full[wr_addr])
        |=> (err_dup && state_q.data[$past(wr_addr)] == $past(state_q.data[wr_addr]))); // R7

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_dup |-> $past(wr_go)); // R7
endmodule

// File: tb/istr_mem_test.sv
module istr_mem_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_ready;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_alloc = 1'b0;
    logic [3:0]  cmd_addr = '0;
    logic [4:0]  cmd_count = '0;
    logic [3:0]  cmd_tag = '0;
    logic        rsp_valid, rsp_busy, err_dup;
    logic [3:0]  rsp_tag;
    logic [15:0] rsp_data;

    int total = 0;
    int bad = 0;
    logic last_ready, last_err;

    // expected item: {busy, tag, data}
    logic [20:0] exp_q[$];
    string       exp_req[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    istr_mem uut (
        .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_alloc(cmd_alloc), .cmd_addr(cmd_addr),
        .cmd_count(cmd_count), .cmd_tag(cmd_tag),
        .rsp_valid(rsp_valid), .rsp_busy(rsp_busy), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data), .err_dup(err_dup)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic exp_ok(input logic [3:0] tag, input logic [15:0] d, input string req);
        exp_q.push_back({1'b0, tag, d});
        exp_req.push_back(req);
    endtask

    task automatic exp_busy(input logic [3:0] tag, input string req);
        exp_q.push_back({1'b1, tag, 16'h0});
        exp_req.push_back(req);
    endtask

    // Monitor: compare every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected response", {11'h0, rsp_busy, rsp_tag, rsp_data}, 32'h0);
            end else begin
                automatic logic [20:0] e = exp_q.pop_front();
                automatic string r = exp_req.pop_front();
                automatic logic [20:0] a = {rsp_busy, rsp_tag, rsp_data};
                if (e[20]) chk(a[20:16] == e[20:16], r, 32'(a), 32'(e));
                else       chk(a == e, r, 32'(a), 32'(e));
            end
        end
    end

    task automatic issue(input logic w, input logic [3:0] wa, input logic [15:0] wd,
                         input logic c, input logic al, input logic [3:0] ca,
                         input logic [4:0] cn, input logic [3:0] ct);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        wr_valid = w;  wr_addr = wa;  wr_data = wd;
        cmd_valid = c; cmd_alloc = al; cmd_addr = ca; cmd_count = cn; cmd_tag = ct;
        @(negedge clk);
        wr_valid = 1'b0;
        cmd_valid = 1'b0;
        last_ready = req_ready;
        last_err = err_dup;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        issue(1'b1, a, d, 1'b0, 1'b0, 4'h0, 5'h0, 4'h0);
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] t);
        issue(1'b0, 4'h0, 16'h0, 1'b1, 1'b0, a, 5'h0, t);
    endtask

    task automatic alloc(input logic [3:0] a, input logic [4:0] n);
        issue(1'b0, 4'h0, 16'h0, 1'b1, 1'b1, a, n, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);
        chk(err_dup == 1'b0, "R1 no error after reset", 32'(err_dup), 32'h0);
        rst_n = 1'b1;

        // R1: slot 0 starts empty, so this read parks
        rd(4'd0, 4'd0);
        exp_ok(4'd0, 16'h1111, "R1 reset slot empty");
        wr(4'd0, 16'h1111);

        // R4: arrival order within a slot, other slots untouched
        rd(4'd3, 4'd1); rd(4'd3, 4'd2); rd(4'd7, 4'd3); rd(4'd3, 4'd4);
        exp_ok(4'd1, 16'hA003, "R4 first parked");
        exp_ok(4'd2, 16'hA003, "R4 second parked");
        exp_ok(4'd4, 16'hA003, "R4 third parked");
        wr(4'd3, 16'hA003);
        chk(last_ready == 1'b0, "R5 ready low while releasing", 32'(last_ready), 32'h0);
        chk(last_err == 1'b0, "R7 no error on first write", 32'(last_err), 32'h0);
        exp_ok(4'd3, 16'hB007, "R4 other slot");
        wr(4'd7, 16'hB007);

        // R3 / R2: read of a full slot
        exp_ok(4'd5, 16'hA003, "R3 full read");
        rd(4'd3, 4'd5);
        chk(last_ready == 1'b1, "R2 ready stays high", 32'(last_ready), 32'h1);

        // R7: duplicate write
        wr(4'd3, 16'hCCCC);
        chk(last_err == 1'b1, "R7 duplicate flagged", 32'(last_err), 32'h1);
        exp_ok(4'd6, 16'hA003, "R7 word unchanged");
        rd(4'd3, 4'd6);
        chk(last_err == 1'b0, "R7 pulse one cycle", 32'(last_err), 32'h0);

        // R9: same-cycle write and read, with an earlier parked reader
        rd(4'd12, 4'd9);
        exp_ok(4'd10, 16'hD00C, "R9 same-cycle read first");
        exp_ok(4'd9, 16'hD00C, "R9 parked reader after");
        issue(1'b1, 4'd12, 16'hD00C, 1'b1, 1'b0, 4'd12, 5'd0, 4'd10);

        // R6: fill the pool, refuse the seventeenth
        for (int t = 0; t < 16; t++) rd(4'd5, 4'(t));
        exp_busy(4'd7, "R6 pool full refused");
        rd(4'd5, 4'd7);
        for (int t = 0; t < 16; t++) exp_ok(4'(t), 16'hE005, "R6 pooled reader released");
        wr(4'd5, 16'hE005);
        // R5: requests while ready is low are ignored
        chk(req_ready == 1'b0, "R5 ready low during release", 32'(req_ready), 32'h0);
        wr_valid = 1'b1; wr_addr = 4'd14; wr_data = 16'hF0F0;
        cmd_valid = 1'b1; cmd_alloc = 1'b0; cmd_addr = 4'd3; cmd_tag = 4'd11;
        @(negedge clk);
        wr_valid = 1'b0; cmd_valid = 1'b0;
        rd(4'd14, 4'd11);
        exp_ok(4'd11, 16'h0E0E, "R5 ignored write had no effect");
        wr(4'd14, 16'h0E0E);
        chk(last_err == 1'b0, "R5 slot was still empty", 32'(last_err), 32'h0);

        // R8: allocate a range
        wr(4'd8, 16'h8888); wr(4'd9, 16'h9999); wr(4'd10, 16'hAAAA);
        rd(4'd11, 4'd12);
        alloc(4'd9, 5'd3);
        exp_ok(4'd13, 16'h8888, "R8 slot outside range kept");
        rd(4'd8, 4'd13);
        rd(4'd9, 4'd14);
        wr(4'd11, 16'h1B1B);
        chk(last_ready == 1'b1, "R8 discarded reader not released", 32'(last_ready), 32'h1);
        chk(last_err == 1'b0, "R8 slot 11 emptied", 32'(last_err), 32'h0);
        exp_ok(4'd14, 16'h2929, "R8 reader parked after allocate");
        wr(4'd9, 16'h2929);
        wr(4'd10, 16'h3A3A);
        chk(last_err == 1'b0, "R8 slot 10 emptied", 32'(last_err), 32'h0);
        alloc(4'd14, 5'd5);
        wr(4'd15, 16'h4F4F);
        chk(last_err == 1'b0, "R8 clipped range emptied last slot", 32'(last_err), 32'h0);
        wr(4'd8, 16'h5858);
        chk(last_err == 1'b1, "R8 slot before range still full", 32'(last_err), 32'h1);

        // R10: allocate and write in the same cycle
        issue(1'b1, 4'd0, 16'h6060, 1'b1, 1'b1, 4'd0, 5'd1, 4'd0);
        chk(last_err == 1'b0, "R10 no error after allocate-then-write", 32'(last_err), 32'h0);
        exp_ok(4'd15, 16'h6060, "R10 new word stored");
        rd(4'd0, 4'd15);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected responses seen", 32'(exp_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule